// File: doc/BRIEF.md
# Flash Embedded-Operation Status Tracker

This block follows the command state of a NOR-style flash device model. It watches qualified write strobes for the multi-cycle unlock sequences that start a program, a sector erase or a whole-array erase. It runs a cycle-count timer for each operation and drives an open-drain-style busy indication, so several instances can share one wired line. Polling reads return a status byte. One bit of that byte flips on every read while an operation runs. A second bit flips only when the read address falls inside the sector that is being erased.

A write of the suspend code during an erase frees the device: it reports ready and the erase timer stops. A write of the resume code starts the erase again for the time that is left. A hardware reset request and a low-supply lockout flag both abandon any operation and return the block to read mode. The memory array, the supply sensing and the pad drivers are not part of this block.

Top module: `flash_op_tracker`

## Requirements
- R1: After reset the block is in read mode: `rb_pull_low` is 0 (ready) and `status_vld` is 0.
- R2: A program starts with the writes 0x555/0xAA, 0x2AA/0x55, 0x555/0xA0 and then any address and data. Only the low `UNL_W` (12) address bits are compared. `rb_pull_low` rises in the cycle after the fourth strobe is captured and stays 0 after the first three.
- R3: An erase starts with the writes 0x555/0xAA, 0x2AA/0x55, 0x555/0x80, 0x555/0xAA, 0x2AA/0x55 and then a sixth write. That write is either data 0x30, which erases the sector given by address bits [15:12], or 0x555/0x10, which erases the whole array. `rb_pull_low` rises in the cycle after the sixth strobe.
- R4: A write that does not match the next expected cycle drops the sequence back to its start, and busy is not asserted. A correct sequence that follows is accepted.
- R5: A program holds `rb_pull_low` high for exactly `PROG_CYC` cycles and an erase for exactly `ERASE_CYC` cycles. The block then returns to read mode.
- R6: While a program or erase runs, all command writes are ignored except data 0xB0 during an erase. A program is not suspended by 0xB0.
- R7: Data 0xB0 written during an erase drops `rb_pull_low` to 0 and freezes the remaining count. Data 0x30 written while suspended raises it again, and the erase ends after the cycles that remained.
- R8: A read strobe yields `status_vld` in the next cycle. The status byte has bit 7 = 1 when no operation runs, bit 6 = a toggle that flips on every read made while busy, bit 2 as in R9, and all other bits 0.
- R9: Status bit 2 flips on a read only while an erase is running (not suspended) and the read address bits [15:12] match the erased sector. During a whole-array erase every address matches.
- R10: `rb_pull_low` is 1 while `hw_reset_req` is high. The running operation is abandoned, and the block is ready once the request drops.
- R11: While `lockout` is high the block returns to read mode in the next cycle and every write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_stb | input | 1 | Qualified write cycle, one pulse per write |
| wr_addr | input | 16 | Write address |
| wr_data | input | 8 | Write data (command code) |
| rd_stb | input | 1 | Status read cycle |
| rd_addr | input | 16 | Read address (sector in top bits) |
| hw_reset_req | input | 1 | Hardware reset request, active high |
| lockout | input | 1 | Low-supply write lockout |
| rb_pull_low | output | 1 | Pull-down enable of the shared ready/busy line (1 = busy) |
| status_vld | output | 1 | Status byte valid |
| status_dq | output | 8 | Polled status byte |

## Verification
Complete program and erase sequences are compared with sequences that break at the third or fifth cycle. This shows that busy depends on the exact cycle count and not on any single code. Reads alternate between the erased sector and another sector, which separates the sector-specific bit from the general toggle bit. A whole-array erase shows that any address matches. A suspend and resume with a fixed wait before the suspend checks that the ready time is the frozen remainder and not a fresh count. A full erase sequence and a suspend code written during a program show that nothing but the erase suspend gets through while busy.

// File: rtl/flash_trk_pkg.sv
package flash_trk_pkg;

  typedef enum logic [1:0] {
    MD_READ,
    MD_PROG,
    MD_ERASE,
    MD_SUSP
  } mode_t;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_UNL1,
    SQ_UNL2,
    SQ_PGM_DATA,
    SQ_ERA_U1,
    SQ_ERA_U2,
    SQ_ERA_CMD
  } seq_t;

  localparam logic [7:0] CD_KEY_A      = 8'hAA;
  localparam logic [7:0] CD_KEY_B      = 8'h55;
  localparam logic [7:0] CD_PROG       = 8'hA0;
  localparam logic [7:0] CD_ERASE_SET  = 8'h80;
  localparam logic [7:0] CD_SECT_ERASE = 8'h30;
  localparam logic [7:0] CD_CHIP_ERASE = 8'h10;
  localparam logic [7:0] CD_SUSPEND    = 8'hB0;
  localparam logic [7:0] CD_RESUME     = 8'h30;

endpackage

// File: rtl/flash_rst_sync.sv
module flash_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_trk_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned UNL_W      = 12,
  parameter int unsigned UNL_ADDR_A = 'h555,
  parameter int unsigned UNL_ADDR_B = 'h2AA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              start_prog,
  output logic              start_erase,
  output logic              erase_chip
);

  localparam logic [UNL_W-1:0] KEY_ADDR_A = UNL_W'(UNL_ADDR_A);
  localparam logic [UNL_W-1:0] KEY_ADDR_B = UNL_W'(UNL_ADDR_B);

  seq_t sq_q, sq_nxt;
  logic hit_a, hit_b;

  assign hit_a = (wr_addr[UNL_W-1:0] == KEY_ADDR_A);
  assign hit_b = (wr_addr[UNL_W-1:0] == KEY_ADDR_B);

  always_comb begin
    sq_nxt      = sq_q;
    start_prog  = 1'b0;
    start_erase = 1'b0;
    erase_chip  = 1'b0;
    if (!enable) begin
      sq_nxt = SQ_IDLE;
    end else if (wr_stb) begin
      // any cycle that does not match falls back to the start
      sq_nxt = SQ_IDLE;
      case (sq_q)
        SQ_IDLE: begin
          if (hit_a && wr_data == CD_KEY_A) sq_nxt = SQ_UNL1;
        end
        SQ_UNL1: begin
          if (hit_b && wr_data == CD_KEY_B) sq_nxt = SQ_UNL2;
        end
        SQ_UNL2: begin
          if (hit_a && wr_data == CD_PROG)           sq_nxt = SQ_PGM_DATA;
          else if (hit_a && wr_data == CD_ERASE_SET) sq_nxt = SQ_ERA_U1;
        end
        SQ_PGM_DATA: begin
          start_prog = 1'b1;
        end
        SQ_ERA_U1: begin
          if (hit_a && wr_data == CD_KEY_A) sq_nxt = SQ_ERA_U2;
        end
        SQ_ERA_U2: begin
          if (hit_b && wr_data == CD_KEY_B) sq_nxt = SQ_ERA_CMD;
        end
        SQ_ERA_CMD: begin
          if (wr_data == CD_SECT_ERASE) begin
            start_erase = 1'b1;
          end else if (hit_a && wr_data == CD_CHIP_ERASE) begin
            start_erase = 1'b1;
            erase_chip  = 1'b1;
          end
        end
        default: sq_nxt = SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq_q <= SQ_IDLE;
    end else begin
      sq_q <= sq_nxt;
    end
  end

endmodule

// File: rtl/flash_op_timer.sv
module flash_op_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             cnt_en;

  assign cnt_en  = load | run;
  assign cnt_nxt = load ? load_val : (cnt_q - CNT_W'(1));
  assign expire  = run && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_nxt;
    end
  end

endmodule

// File: rtl/flash_status_poll.sv
module flash_status_poll #(
  parameter int unsigned SECT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_stb,
  input  logic [SECT_W-1:0] rd_sector,
  input  logic              busy,
  input  logic              erasing,
  input  logic              erase_all,
  input  logic [SECT_W-1:0] erase_sector,
  output logic              status_vld,
  output logic [7:0]        status_dq
);

  logic tog_any_q, tog_sect_q;
  logic tog_any_nxt, tog_sect_nxt;
  logic sect_hit;

  assign sect_hit     = erasing && (erase_all || rd_sector == erase_sector);
  assign tog_any_nxt  = tog_any_q ^ busy;
  assign tog_sect_nxt = tog_sect_q ^ sect_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_vld <= 1'b0;
    end else begin
      status_vld <= rd_stb;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_any_q  <= 1'b0;
      tog_sect_q <= 1'b0;
      status_dq  <= 8'h00;
    end else if (rd_stb) begin
      tog_any_q  <= tog_any_nxt;
      tog_sect_q <= tog_sect_nxt;
      status_dq  <= {!busy, tog_any_nxt, 3'b000, tog_sect_nxt, 2'b00};
    end
  end

endmodule

// File: rtl/flash_op_tracker.sv
module flash_op_tracker
  import flash_trk_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned SECT_W    = 4,
  parameter int unsigned UNL_W     = 12,
  parameter int unsigned PROG_CYC  = 16,
  parameter int unsigned ERASE_CYC = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              rd_stb,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              hw_reset_req,
  input  logic              lockout,
  output logic              rb_pull_low,
  output logic              status_vld,
  output logic [7:0]        status_dq
);

  localparam int unsigned MAX_CYC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

  logic              rst_sync_n;
  mode_t             mode_q, mode_nxt;
  logic [SECT_W-1:0] era_sect_q;
  logic              era_all_q;
  logic              ctl_ok, dec_en;
  logic              start_prog, start_erase, erase_chip;
  logic              tmr_load, tmr_run, tmr_expire;
  logic [CNT_W-1:0]  tmr_val;
  logic              op_busy, op_erasing;
  logic              rd_addr_unused;

  flash_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign ctl_ok = !hw_reset_req && !lockout;
  assign dec_en = ctl_ok && (mode_q == MD_READ);

  flash_cmd_seq #(
    .ADDR_W (ADDR_W),
    .UNL_W  (UNL_W)
  ) i_cmd_seq (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .enable      (dec_en),
    .wr_stb      (wr_stb),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .start_prog  (start_prog),
    .start_erase (start_erase),
    .erase_chip  (erase_chip)
  );

  assign tmr_load = start_prog | start_erase;
  assign tmr_val  = start_prog ? CNT_W'(PROG_CYC) : CNT_W'(ERASE_CYC);
  assign tmr_run  = ctl_ok && (mode_q == MD_PROG || mode_q == MD_ERASE);

  flash_op_timer #(.CNT_W(CNT_W)) i_timer (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .run      (tmr_run),
    .expire   (tmr_expire)
  );

  always_comb begin
    mode_nxt = mode_q;
    if (!ctl_ok) begin
      mode_nxt = MD_READ;
    end else begin
      case (mode_q)
        MD_READ: begin
          if (start_prog)       mode_nxt = MD_PROG;
          else if (start_erase) mode_nxt = MD_ERASE;
        end
        MD_PROG: begin
          if (tmr_expire) mode_nxt = MD_READ;
        end
        MD_ERASE: begin
          if (tmr_expire)                              mode_nxt = MD_READ;
          else if (wr_stb && wr_data == CD_SUSPEND)    mode_nxt = MD_SUSP;
        end
        MD_SUSP: begin
          if (wr_stb && wr_data == CD_RESUME) mode_nxt = MD_ERASE;
        end
        default: mode_nxt = MD_READ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mode_q <= MD_READ;
    end else begin
      mode_q <= mode_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      era_sect_q <= '0;
      era_all_q  <= 1'b0;
    end else if (start_erase) begin
      era_sect_q <= wr_addr[ADDR_W-1 -: SECT_W];
      era_all_q  <= erase_chip;
    end
  end

  assign op_busy     = (mode_q == MD_PROG) || (mode_q == MD_ERASE);
  assign op_erasing  = (mode_q == MD_ERASE);
  assign rb_pull_low = hw_reset_req || op_busy;

  assign rd_addr_unused = ^rd_addr[ADDR_W-SECT_W-1:0];

  flash_status_poll #(.SECT_W(SECT_W)) i_status (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .rd_stb       (rd_stb),
    .rd_sector    (rd_addr[ADDR_W-1 -: SECT_W]),
    .busy         (op_busy),
    .erasing      (op_erasing),
    .erase_all    (era_all_q),
    .erase_sector (era_sect_q),
    .status_vld   (status_vld),
    .status_dq    (status_dq)
  );

endmodule

// File: rtl/flash_op_tracker_chk.sv
module flash_op_tracker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_stb,
  input logic       rd_stb,
  input logic       hw_reset_req,
  input logic       lockout,
  input logic       rb_pull_low,
  input logic       status_vld,
  input logic [7:0] status_dq
);

  // R8
  rd_gives_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> status_vld);

  // R8
  no_rd_no_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> !status_vld);

  // R8
  ready_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_vld && !$past(hw_reset_req)) |-> (status_dq[7] == !$past(rb_pull_low)));

  // R9
  idle_toggles_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_vld && !$past(rb_pull_low)) |->
      (status_dq[6] == $past(status_dq[6]) && status_dq[2] == $past(status_dq[2])));

  // R10
  reset_release_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hw_reset_req) |-> !rb_pull_low);

  // R11
  lockout_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lockout && !hw_reset_req) |=> (!rb_pull_low || hw_reset_req));

  // R2 R3
  busy_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rb_pull_low) && !hw_reset_req) |-> $past(wr_stb));

endmodule

bind flash_op_tracker flash_op_tracker_chk i_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .wr_stb       (wr_stb),
  .rd_stb       (rd_stb),
  .hw_reset_req (hw_reset_req),
  .lockout      (lockout),
  .rb_pull_low  (rb_pull_low),
  .status_vld   (status_vld),
  .status_dq    (status_dq)
);

// File: tb/test_flash_op_tracker.sv
`timescale 1ns/1ps
module test_flash_op_tracker;

  localparam int P = 16;
  localparam int E = 64;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_stb, rd_stb, hw_reset_req, lockout;
  logic [15:0] wr_addr, rd_addr;
  logic [7:0]  wr_data;
  logic        rb_pull_low, status_vld;
  logic [7:0]  status_dq;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  bit e6 = 1'b0;
  bit e2 = 1'b0;
  logic [7:0] exp_q[$];
  string      exp_tag[$];

  always #2.5 clk = ~clk;

  flash_op_tracker #(.PROG_CYC(P), .ERASE_CYC(E)) i_flash_op_tracker (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_stb(rd_stb), .rd_addr(rd_addr), .hw_reset_req(hw_reset_req), .lockout(lockout),
    .rb_pull_low(rb_pull_low), .status_vld(status_vld), .status_dq(status_dq)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_stb = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  // driver: pushes the expected status byte, then strobes the read
  task automatic rd(input logic [15:0] a, input bit busy, input bit flip2, input string rq);
    @(negedge clk);
    if (busy) e6 = ~e6;
    if (flip2) e2 = ~e2;
    exp_q.push_back({~busy, e6, 3'b000, e2, 2'b00});
    exp_tag.push_back(rq);
    rd_stb = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic chk_rb(input bit exp, input string rq);
    chk(rb_pull_low == exp, rq, rb_pull_low, exp);
  endtask

  task automatic unlock_erase();
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55); wr(16'h0555, 8'h80);
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55);
  endtask

  task automatic unlock_prog();
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55); wr(16'h0555, 8'hA0);
  endtask

  // monitor: compares each produced status byte with the queue head
  always @(negedge clk) begin
    if (rst_n && status_vld) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8 unexpected status", status_dq, 0);
      end else begin
        logic [7:0] ev;
        string      tg;
        ev = exp_q.pop_front();
        tg = exp_tag.pop_front();
        chk(status_dq == ev, tg, status_dq, ev);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0h expected %0h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_stb = 1'b0; rd_stb = 1'b0; hw_reset_req = 1'b0; lockout = 1'b0;
    wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk_rb(1'b0, "R1 ready after reset");
    chk(status_vld == 1'b0, "R1 no status after reset", status_vld, 0);
    rd(16'h0000, 1'b0, 1'b0, "R8 idle read");

    // R2 program start point, R5 program duration
    unlock_prog();
    chk_rb(1'b0, "R2 not busy after three cycles");
    wr(16'h1234, 8'h5A);
    chk_rb(1'b1, "R2 busy after fourth cycle");
    repeat (P-1) @(negedge clk);
    chk_rb(1'b1, "R5 program busy to last cycle");
    @(negedge clk);
    chk_rb(1'b0, "R5 program ends");

    // R8 reads while programming toggle bit 6 only
    unlock_prog(); wr(16'h2000, 8'h11);
    rd(16'h2000, 1'b1, 1'b0, "R8 read during program");
    rd(16'h2000, 1'b1, 1'b0, "R8 second read during program");
    repeat (P) @(negedge clk);
    chk_rb(1'b0, "R5 ready after program with reads");

    // R3 sector erase, R9 sector-specific toggle
    unlock_erase();
    chk_rb(1'b0, "R3 not busy after five cycles");
    wr(16'h3000, 8'h30);
    chk_rb(1'b1, "R3 busy after sixth cycle");
    rd(16'h3ABC, 1'b1, 1'b1, "R9 erased sector read");
    rd(16'h5000, 1'b1, 1'b0, "R9 other sector read");
    rd(16'h3FFF, 1'b1, 1'b1, "R9 erased sector read again");
    repeat (E) @(negedge clk);
    chk_rb(1'b0, "R5 erase ends");
    rd(16'h3000, 1'b0, 1'b0, "R9 no toggle after erase");

    // R7 suspend and resume with frozen remainder, R5 erase duration
    unlock_erase(); wr(16'h2000, 8'h30);
    repeat (5) @(negedge clk);
    wr(16'h0000, 8'hB0);
    chk_rb(1'b0, "R7 ready when suspended");
    rd(16'h2000, 1'b0, 1'b0, "R7 suspended read");
    repeat (10) @(negedge clk);
    chk_rb(1'b0, "R7 stays ready while suspended");
    wr(16'h0000, 8'h30);
    chk_rb(1'b1, "R7 busy after resume");
    repeat (E-8) @(negedge clk);
    chk_rb(1'b1, "R7 busy for remaining count");
    @(negedge clk);
    chk_rb(1'b0, "R7 erase ends after remainder");

    // R6 commands during a program are ignored
    unlock_prog(); wr(16'h4000, 8'h22);
    unlock_erase(); wr(16'h4000, 8'h30); wr(16'h0000, 8'hB0);
    chk_rb(1'b1, "R6 program not suspended");
    repeat (P-15) @(negedge clk);
    chk_rb(1'b1, "R6 program still on its own count");
    @(negedge clk);
    chk_rb(1'b0, "R6 program ends on time");
    repeat (4) @(negedge clk);
    chk_rb(1'b0, "R6 erase written while busy not started");

    // R4 wrong cycles abort the sequence
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55); wr(16'h0555, 8'h77);
    wr(16'h0555, 8'hA0); wr(16'h0100, 8'h12);
    chk_rb(1'b0, "R4 bad third cycle aborts");
    wr(16'h0555, 8'hAA); wr(16'h02AA, 8'h55); wr(16'h0555, 8'h80);
    wr(16'h0555, 8'hAA); wr(16'h0555, 8'h55); wr(16'h3000, 8'h30);
    chk_rb(1'b0, "R4 bad fifth address aborts");
    unlock_prog(); wr(16'h0100, 8'h12);
    chk_rb(1'b1, "R4 valid sequence after abort");
    repeat (P) @(negedge clk);

    // R3 whole-array erase, R9 every sector matches, R10 hardware reset
    unlock_erase(); wr(16'h0555, 8'h10);
    chk_rb(1'b1, "R3 chip erase busy");
    rd(16'h7000, 1'b1, 1'b1, "R9 chip erase any sector");
    rd(16'h0000, 1'b1, 1'b1, "R9 chip erase sector zero");
    @(negedge clk); hw_reset_req = 1'b1;
    @(negedge clk);
    chk_rb(1'b1, "R10 busy during reset");
    repeat (4) @(negedge clk);
    hw_reset_req = 1'b0;
    @(negedge clk);
    chk_rb(1'b0, "R10 ready after reset");
    repeat (10) @(negedge clk);
    chk_rb(1'b0, "R10 erase abandoned");

    // R11 lockout
    lockout = 1'b1;
    unlock_prog(); wr(16'h0100, 8'h12);
    chk_rb(1'b0, "R11 writes ignored in lockout");
    lockout = 1'b0;
    unlock_prog(); wr(16'h0100, 8'h12);
    chk_rb(1'b1, "R11 program after lockout clears");
    lockout = 1'b1;
    @(negedge clk);
    chk_rb(1'b0, "R11 lockout aborts program");
    lockout = 1'b0;
    repeat (3) @(negedge clk);
    chk_rb(1'b0, "R11 stays in read mode");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R8 all reads answered", exp_q.size(), 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule